// File: doc/BRIEF.md
# Transmit Completion Entry Generator

This block sits beside a network transmit engine and turns its completion events into 32-bit entries for a completion ring in host memory. An event arrives on one of two source strobes. The first fires when the host-to-device DMA of a packet has finished. The second fires when the packet has been sent on the wire. Each event carries three things: a bit that names the transmit queue (high or low priority), the descriptor position as a byte offset into the descriptor queue, and, for wire completion only, a 13-bit status word.

The block packs each accepted event into a single word and presents it on a valid/ready output. It also keeps a producer offset into the completion ring. This offset moves forward by one entry size (4 bytes) for every word the consumer accepts. If both sources fire in the same cycle, the DMA entry goes out first. The wire entry waits in a one-deep holding register. No event is ever lost. When the block cannot take more, it lowers the ready signal toward both sources.

Top module: `txc_entry_gen`

## Requirements
- R1: After reset, `entry_valid_o` is 0, `prod_idx_o` is 0, and both source ready outputs are 1.
- R2: An accepted DMA event produces a word with bits [31:29] = 3'b100, bit [28] = queue bit, bits [27:15] = `timer_i[12:0]` sampled in the acceptance cycle, and bits [14:0] = descriptor byte offset.
- R3: An accepted wire event produces a word with bits [31:29] = 3'b101, bit [28] = queue bit, bits [27:15] = status, and bits [14:0] = descriptor byte offset.
- R4: A word appears on the output in the cycle after its event is accepted. While `entry_valid_o` is 1 and `entry_ready_i` is 0, the word and the valid signal hold steady.
- R5: When both sources are accepted in the same cycle, the DMA word is output before the wire word.
- R6: Every accepted event produces exactly one output word, in acceptance order. While the output is stalled, both source ready outputs are 0.
- R7: `prod_idx_o` advances by 4 on each output handshake. It wraps to 0 after reaching RING_BYTES-4, and otherwise holds its value.
- R8: While the holding register is occupied, both source ready outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| timer_i | input | 32 | Free-running timer |
| dma_valid_i | input | 1 | DMA-done event strobe |
| dma_ready_o | output | 1 | Block can take a DMA-done event |
| dma_prio_i | input | 1 | Queue bit of the DMA-done event |
| dma_idx_i | input | 15 | Descriptor byte offset of the DMA-done event |
| txd_valid_i | input | 1 | Wire-done event strobe |
| txd_ready_o | output | 1 | Block can take a wire-done event |
| txd_prio_i | input | 1 | Queue bit of the wire-done event |
| txd_idx_i | input | 15 | Descriptor byte offset of the wire-done event |
| txd_status_i | input | 13 | Transmit status of the wire-done event |
| entry_o | output | 32 | Completion word |
| entry_valid_o | output | 1 | Completion word is valid |
| entry_ready_i | input | 1 | Consumer takes the word |
| prod_idx_o | output | PTR_W | Completion ring producer byte offset |

## Verification
The hardest state to reach is a full holding register with a stalled consumer. To get there, both sources must be accepted in the same cycle, and then `entry_ready_i` must stay low so the second word cannot move. The stimulus therefore raises both strobes together with high probability and lowers the consumer ready in long random runs. This builds up stretches where the source readies stay low for many cycles and then release in the right order. A long accepting run then pushes the producer offset through several wraps.

// File: rtl/txc_pkg.sv
package txc_pkg;
  localparam int unsigned KIND_W = 3;
  localparam int unsigned INFO_W = 13;
  localparam int unsigned IDX_W  = 15;
  localparam int unsigned WORD_W = KIND_W + 1 + INFO_W + IDX_W;

  typedef enum logic [KIND_W-1:0] {
    KIND_DMA_DONE = 3'b100,
    KIND_TX_DONE  = 3'b101
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic              prio;
    logic [INFO_W-1:0] info;
    logic [IDX_W-1:0]  idx;
  } entry_t;
endpackage

// File: rtl/txc_entry_pack.sv
module txc_entry_pack
  import txc_pkg::*;
#(
  parameter kind_e KIND = KIND_DMA_DONE
) (
  input  logic              prio_i,
  input  logic [INFO_W-1:0] info_i,
  input  logic [IDX_W-1:0]  idx_i,
  output entry_t            entry_o
);
  always_comb begin
    entry_o.kind = KIND;
    entry_o.prio = prio_i;
    entry_o.info = info_i;
    entry_o.idx  = idx_i;
  end
endmodule

// File: rtl/txc_hold_reg.sv
module txc_hold_reg
  import txc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   set_i,
  input  logic   clr_i,
  input  entry_t data_i,
  output logic   vld_o,
  output entry_t data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      data_o <= '0;
    end else if (set_i) begin
      vld_o  <= 1'b1;
      data_o <= data_i;
    end else if (clr_i) begin
      vld_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/txc_ring_ptr.sv
module txc_ring_ptr #(
  parameter int unsigned RING_BYTES = 64,
  parameter int unsigned STEP       = 4,
  localparam int unsigned PTR_W     = $clog2(RING_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(RING_BYTES - STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (adv_i) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + PTR_W'(STEP);
  end
endmodule

// File: rtl/txc_entry_gen.sv
module txc_entry_gen
  import txc_pkg::*;
#(
  parameter int unsigned RING_BYTES = 64,
  localparam int unsigned PTR_W     = $clog2(RING_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       timer_i,
  input  logic              dma_valid_i,
  output logic              dma_ready_o,
  input  logic              dma_prio_i,
  input  logic [IDX_W-1:0]  dma_idx_i,
  input  logic              txd_valid_i,
  output logic              txd_ready_o,
  input  logic              txd_prio_i,
  input  logic [IDX_W-1:0]  txd_idx_i,
  input  logic [INFO_W-1:0] txd_status_i,
  output logic [WORD_W-1:0] entry_o,
  output logic              entry_valid_o,
  input  logic              entry_ready_i,
  output logic [PTR_W-1:0]  prod_idx_o
);
  entry_t dma_word, txd_word, skid_word, out_q;
  logic   out_vld_q, skid_vld, load_ok, src_rdy, dma_fire, txd_fire;

  txc_entry_pack #(.KIND(KIND_DMA_DONE)) i_pack_dma (
    .prio_i (dma_prio_i),
    .info_i (timer_i[INFO_W-1:0]),
    .idx_i  (dma_idx_i),
    .entry_o(dma_word)
  );

  txc_entry_pack #(.KIND(KIND_TX_DONE)) i_pack_txd (
    .prio_i (txd_prio_i),
    .info_i (txd_status_i),
    .idx_i  (txd_idx_i),
    .entry_o(txd_word)
  );

  // output slot free or draining this cycle
  assign load_ok     = !out_vld_q || entry_ready_i;
  assign src_rdy     = load_ok && !skid_vld;
  assign dma_ready_o = src_rdy;
  assign txd_ready_o = src_rdy;
  assign dma_fire    = dma_valid_i && src_rdy;
  assign txd_fire    = txd_valid_i && src_rdy;

  // wire-done word parks here when both sources fire together
  txc_hold_reg i_skid (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (dma_fire && txd_fire),
    .clr_i (load_ok),
    .data_i(txd_word),
    .vld_o (skid_vld),
    .data_o(skid_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_q <= 1'b0;
      out_q     <= '0;
    end else if (load_ok) begin
      if (skid_vld) begin
        out_vld_q <= 1'b1;
        out_q     <= skid_word;
      end else if (dma_fire) begin
        out_vld_q <= 1'b1;
        out_q     <= dma_word;
      end else if (txd_fire) begin
        out_vld_q <= 1'b1;
        out_q     <= txd_word;
      end else begin
        out_vld_q <= 1'b0;
      end
    end
  end

  assign entry_o       = out_q;
  assign entry_valid_o = out_vld_q;

  txc_ring_ptr #(.RING_BYTES(RING_BYTES), .STEP(WORD_W / 8)) i_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (out_vld_q && entry_ready_i),
    .ptr_o (prod_idx_o)
  );
endmodule

// File: rtl/txc_entry_gen_chk.sv
module txc_entry_gen_chk #(
  parameter int unsigned RING_BYTES = 64,
  localparam int unsigned PTR_W     = $clog2(RING_BYTES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dma_valid_i,
  input logic             dma_ready_o,
  input logic             txd_valid_i,
  input logic             txd_ready_o,
  input logic [31:0]      entry_o,
  input logic             entry_valid_o,
  input logic             entry_ready_i,
  input logic [PTR_W-1:0] prod_idx_o
);
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_valid_o && !entry_ready_i |=> entry_valid_o && $stable(entry_o)); // R4

  AST_KIND_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_valid_o |-> (entry_o[31:29] == 3'b100 || entry_o[31:29] == 3'b101)); // R2

  AST_STALL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_valid_o && !entry_ready_i |-> !dma_ready_o && !txd_ready_o); // R6

  AST_DMA_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_valid_i && dma_ready_o && txd_valid_i && txd_ready_o
    |=> entry_valid_o && entry_o[31:29] == 3'b100 && !dma_ready_o && !txd_ready_o); // R5

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_valid_o && entry_ready_i
    |=> prod_idx_o == PTR_W'((int'($past(prod_idx_o)) + 4) % RING_BYTES)); // R7

  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(entry_valid_o && entry_ready_i) |=> $stable(prod_idx_o)); // R7
endmodule

bind txc_entry_gen txc_entry_gen_chk #(.RING_BYTES(RING_BYTES)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dma_valid_i  (dma_valid_i),
  .dma_ready_o  (dma_ready_o),
  .txd_valid_i  (txd_valid_i),
  .txd_ready_o  (txd_ready_o),
  .entry_o      (entry_o),
  .entry_valid_o(entry_valid_o),
  .entry_ready_i(entry_ready_i),
  .prod_idx_o   (prod_idx_o)
);

// File: tb/test_txc_entry_gen.sv
module test_txc_entry_gen;
  localparam int CLK_PERIOD = 10;
  localparam int RING       = 64;
  localparam int PW         = $clog2(RING);

  logic clk_i = 0, rst_ni = 0;
  logic [31:0] timer_i = 32'h1234_5F00;
  logic dma_valid_i = 0, dma_prio_i = 0, txd_valid_i = 0, txd_prio_i = 0, entry_ready_i = 0;
  logic [14:0] dma_idx_i = 0, txd_idx_i = 0;
  logic [12:0] txd_status_i = 0;
  logic dma_ready_o, txd_ready_o, entry_valid_o;
  logic [31:0] entry_o;
  logic [PW-1:0] prod_idx_o;

  int n_chk = 0, n_bad = 0;
  logic [31:0] q[$];
  int m_prod = 0;
  bit prev_stall = 0, prev_both = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  txc_entry_gen #(.RING_BYTES(RING)) i_txc_entry_gen (.*);

  // behavioural reference model
  always @(posedge clk_i) begin
    if (rst_ni) begin
      bit rdy;
      rdy = (q.size() == 0) || (q.size() == 1 && entry_ready_i);
      prev_stall = (q.size() > 0) && !entry_ready_i;
      prev_both  = rdy && dma_valid_i && txd_valid_i;
      if (q.size() > 0 && entry_ready_i) begin
        void'(q.pop_front());
        m_prod = (m_prod + 4) % RING;
      end
      if (rdy && dma_valid_i) q.push_back({3'b100, dma_prio_i, timer_i[12:0], dma_idx_i});
      if (rdy && txd_valid_i) q.push_back({3'b101, txd_prio_i, txd_status_i, txd_idx_i});
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit e_vld, e_rdy;
    e_vld = q.size() > 0;
    e_rdy = (q.size() == 0) || (q.size() == 1 && entry_ready_i);
    chk("R6 valid", 32'(entry_valid_o), 32'(e_vld));
    chk(q.size() == 2 ? "R8 dma_ready" : "R6 dma_ready", 32'(dma_ready_o), 32'(e_rdy));
    chk(q.size() == 2 ? "R8 txd_ready" : "R6 txd_ready", 32'(txd_ready_o), 32'(e_rdy));
    chk("R7 prod_idx", 32'(prod_idx_o), 32'(m_prod));
    if (e_vld) begin
      if (prev_stall)     chk("R4 entry", entry_o, q[0]);
      else if (prev_both) chk("R5 entry", entry_o, q[0]);
      else if (q[0][31:29] == 3'b100) chk("R2 entry", entry_o, q[0]);
      else                chk("R3 entry", entry_o, q[0]);
    end
  endtask

  task automatic run(input int cycles, input int p_dma, input int p_txd, input int p_rdy);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_i);
      timer_i++;
      dma_valid_i   = ($urandom % 100) < p_dma;
      txd_valid_i   = ($urandom % 100) < p_txd;
      entry_ready_i = ($urandom % 100) < p_rdy;
      dma_prio_i    = $urandom;
      txd_prio_i    = $urandom;
      dma_idx_i     = 15'($urandom) & 15'h7FF0;
      txd_idx_i     = 15'($urandom) & 15'h7FF0;
      txd_status_i  = 13'($urandom);
      #1 compare();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    // R1 reset state
    chk("R1 valid", 32'(entry_valid_o), 0);
    chk("R1 prod_idx", 32'(prod_idx_o), 0);
    chk("R1 dma_ready", 32'(dma_ready_o), 1);
    chk("R1 txd_ready", 32'(txd_ready_o), 1);
    @(negedge clk_i);
    rst_ni = 1;
    run(300, 40, 0, 100);   // R2 DMA-only, free consumer
    run(300, 0, 40, 100);   // R3 wire-only
    run(800, 70, 70, 30);   // R4 R5 R8 collisions with stalls
    run(600, 50, 50, 100);  // R7 many wraps
    run(600, 60, 60, 60);   // R6 mixed
    run(50, 0, 0, 100);     // drain
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule